// File: doc/BRIEF.md
# Multiplexed External Byte-Bus Controller

This block turns single read, write and instruction-fetch requests from a processor core into cycles on an external bus. The bus carries the low address byte and the data on one shared 8-bit lane and the upper address byte on a separate lane. One configuration value picks the address strobe style. The strobe can be a short positive latch pulse, or an active-low "address valid" level that stays low for the whole cycle. The same value sets how many wait states a slow device may request through the ready input before the controller ends the cycle anyway.

Requests to a fixed 8 KB window can be served by on-chip memory instead of the bus. A strap input chooses between the two, and the controller steers the request to a simple internal memory port. That port returns data one cycle after it is enabled.

A 16-bit request goes out as two byte cycles, low byte first. The controller joins the two read bytes into one response word. Every request ends with a single-cycle response pulse, for reads and for writes.

Top module: `xbus_ctrl`

## Requirements
- R1: A request whose address lies in 2000h..3FFFh while `ea_i` is high goes to the internal port. `int_en_o` pulses for one cycle, `rd_n_o`, `wr_n_o` and `inst_o` stay inactive, and the response comes two cycles after `int_en_o`. A request anywhere else, or with `ea_i` low, runs an external bus cycle.
- R2: With `cfg_i[0]`=0 (latch-pulse style), `strb_o` is high only for the single address cycle of each byte cycle, the cycle right after the request is accepted.
- R3: With `cfg_i[0]`=1 (address-valid style), `strb_o` is low from the address cycle through the last read/write strobe cycle, and high in the hold cycle that ends each byte cycle.
- R4: In the address cycle, `ahi_o` carries address bits 15:8, `ad_o` carries bits 7:0 and `ad_oe_o` is 1.
- R5: A read drives `rd_n_o` low for the strobe period and samples `ad_i` in its last cycle. `rsp_valid_o` pulses the cycle after the final hold cycle. `rsp_rdata_o` holds the byte in bits 7:0 with the upper bits zero for a byte read.
- R6: A write drives `wr_n_o` low for the strobe period with `ad_oe_o`=1 and the data byte on `ad_o`. `rd_n_o` and `wr_n_o` are never low together.
- R7: `inst_o` is high from the address cycle through the hold cycle of a fetch, and low for data cycles, internal accesses and idle.
- R8: The strobe period is 1 cycle. `ready_i` is sampled at its end and again at the end of each wait state. Each sample found low inserts one wait state of 2 cycles, until the limit is reached.
- R9: `cfg_i[3:2]` caps the wait states per byte cycle at 0..3. `cfg_i[1]`=1 removes the cap. Configuration is captured when a request is accepted.
- R10: A 16-bit request (`req_wide_i`=1) runs two byte cycles, at the address and at address+1, low byte first. Read data returns as {second byte, first byte}.
- R11: After reset, `rd_n_o`=`wr_n_o`=1, `ad_oe_o`=0, `inst_o`=0, `rsp_valid_o`=0 and `req_ready_o`=1. While idle, `strb_o` sits at the inactive level of the style selected by `cfg_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per bus phase |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 4 | [0] strobe style, [1] unlimited waits, [3:2] wait cap |
| ea_i | input | 1 | High: window 2000h..3FFFh is internal |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_fetch_i | input | 1 | Read is an instruction fetch |
| req_wide_i | input | 1 | 16-bit request |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 16 | Write data, low byte first on the bus |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read data |
| int_en_o | output | 1 | Internal memory enable |
| int_we_o | output | 1 | Internal write enable |
| int_wide_o | output | 1 | Internal access is 16-bit |
| int_addr_o | output | 16 | Internal address |
| int_wdata_o | output | 16 | Internal write data |
| int_rdata_i | input | 16 | Internal read data, valid the cycle after enable |
| ad_o | output | 8 | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 8 | Multiplexed data in |
| ahi_o | output | 8 | Upper address byte |
| strb_o | output | 1 | Address strobe (latch pulse or address-valid level) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inst_o | output | 1 | Fetch indicator |
| ready_i | input | 1 | Device ready, low requests wait states |

## Verification
The hardest case to reach is a device that keeps `ready_i` low past the configured cap. The capped, shortened strobe period shows up only when the ready pattern runs longer than the limit. The stimulus therefore holds `ready_i` low for a set number of strobe cycles per byte, and the bench works out the expected wait count as the smaller of that span's sample points and the cap. Then it checks the exact cycle in which the strobe rises. The wide-access case crosses a 256-byte boundary, so the second address also carries into the upper byte lane.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int LIM_W = 2;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_STRB,
    XS_WAIT0,
    XS_WAIT1,
    XS_HOLD,
    XS_INT,
    XS_INTRD
  } xbus_state_e;

  typedef struct packed {
    logic [LIM_W-1:0] lim;
    logic             unlim;
    logic             adv;
  } xbus_cfg_t;

  localparam int CFG_W = $bits(xbus_cfg_t);

endpackage

// File: rtl/xbus_route.sv
module xbus_route #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'h3FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ea_i,
  output logic              internal_o
);

  logic in_window;

  assign in_window  = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
  assign internal_o = ea_i && in_window;

endmodule

// File: rtl/xbus_wait.sv
module xbus_wait #(
  parameter int CNT_W = 3,
  parameter int LIM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             unlim_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             may_wait_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign may_wait_o = unlim_i || (cnt_q < CNT_W'(limit_i));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  xbus_state_e              state_d_i,
  input  logic                     adv_i,
  input  logic                     write_i,
  input  logic                     fetch_i,
  input  logic [ADDR_W-1:0]        baddr_i,
  input  logic [DATA_W-1:0]        wbyte_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] ahi_o,
  output logic                     strb_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     inst_o
);

  localparam int HI_W = ADDR_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
      ahi_o   <= '0;
      strb_o  <= 1'b0;
      rd_n_o  <= 1'b1;
      wr_n_o  <= 1'b1;
      inst_o  <= 1'b0;
    end else begin
      case (state_d_i)
        XS_ADDR: begin
          ad_o    <= baddr_i[DATA_W-1:0];
          ahi_o   <= baddr_i[ADDR_W-1 -: HI_W];
          ad_oe_o <= 1'b1;
          strb_o  <= ~adv_i;
          rd_n_o  <= 1'b1;
          wr_n_o  <= 1'b1;
          inst_o  <= fetch_i;
        end
        XS_STRB, XS_WAIT0, XS_WAIT1: begin
          if (write_i) ad_o <= wbyte_i;
          ad_oe_o <= write_i;
          strb_o  <= 1'b0;
          rd_n_o  <= write_i;
          wr_n_o  <= ~write_i;
          inst_o  <= fetch_i;
        end
        XS_HOLD: begin
          ad_oe_o <= write_i;
          strb_o  <= adv_i;
          rd_n_o  <= 1'b1;
          wr_n_o  <= 1'b1;
          inst_o  <= fetch_i;
        end
        default: begin
          ad_oe_o <= 1'b0;
          strb_o  <= adv_i;
          rd_n_o  <= 1'b1;
          wr_n_o  <= 1'b1;
          inst_o  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 8,
  parameter int                CNT_W  = 3,
  parameter logic [ADDR_W-1:0] WIN_LO = 16'h2000,
  parameter logic [ADDR_W-1:0] WIN_HI = 16'h3FFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [3:0]               cfg_i,
  input  logic                     ea_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic                     req_fetch_i,
  input  logic                     req_wide_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [2*DATA_W-1:0]      req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [2*DATA_W-1:0]      rsp_rdata_o,
  output logic                     int_en_o,
  output logic                     int_we_o,
  output logic                     int_wide_o,
  output logic [ADDR_W-1:0]        int_addr_o,
  output logic [2*DATA_W-1:0]      int_wdata_o,
  input  logic [2*DATA_W-1:0]      int_rdata_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] ahi_o,
  output logic                     strb_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     inst_o,
  input  logic                     ready_i
);

  localparam int WORD_W = 2 * DATA_W;

  xbus_cfg_t   cfg_in;
  xbus_state_e state_q, state_d;

  logic              is_int, may_wait, go_wait, step_strb, accept, idle;
  logic              wr_q, fetch_q, wide_q, bsel_q, adv_q, unlim_q;
  logic [LIM_W-1:0]  lim_q;
  logic [ADDR_W-1:0] addr_q, baddr;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [DATA_W-1:0] wbyte;
  logic              cur_write, cur_fetch, cur_adv, rsp_q;

  assign cfg_in = xbus_cfg_t'(cfg_i[CFG_W-1:0]);

  xbus_route #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_route (
    .addr_i     (req_addr_i),
    .ea_i       (ea_i),
    .internal_o (is_int)
  );

  assign idle      = (state_q == XS_IDLE);
  assign accept    = idle && req_valid_i;
  assign step_strb = (state_q == XS_STRB) || (state_q == XS_WAIT1);
  assign go_wait   = step_strb && !ready_i && may_wait;

  xbus_wait #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_wait (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (state_d == XS_ADDR),
    .inc_i      (go_wait),
    .unlim_i    (unlim_q),
    .limit_i    (lim_q),
    .may_wait_o (may_wait)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:  if (req_valid_i) state_d = is_int ? XS_INT : XS_ADDR;
      XS_ADDR:  state_d = XS_STRB;
      XS_STRB:  state_d = go_wait ? XS_WAIT0 : XS_HOLD;
      XS_WAIT0: state_d = XS_WAIT1;
      XS_WAIT1: state_d = go_wait ? XS_WAIT0 : XS_HOLD;
      XS_HOLD:  state_d = (wide_q && !bsel_q) ? XS_ADDR : XS_IDLE;
      XS_INT:   state_d = XS_INTRD;
      XS_INTRD: state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  assign cur_write = idle ? req_write_i : wr_q;
  assign cur_fetch = idle ? (req_fetch_i && !req_write_i) : fetch_q;
  assign cur_adv   = idle ? cfg_in.adv : adv_q;
  assign baddr     = idle ? req_addr_i : addr_q + ADDR_W'(1);
  assign wbyte     = bsel_q ? wdata_q[WORD_W-1:DATA_W] : wdata_q[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      wr_q    <= 1'b0;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      bsel_q  <= 1'b0;
      adv_q   <= 1'b0;
      unlim_q <= 1'b0;
      lim_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= ((state_q == XS_HOLD) && (state_d == XS_IDLE)) || (state_q == XS_INTRD);
      if (accept) begin
        wr_q    <= req_write_i;
        fetch_q <= req_fetch_i && !req_write_i;
        wide_q  <= req_wide_i;
        bsel_q  <= 1'b0;
        adv_q   <= cfg_in.adv;
        unlim_q <= cfg_in.unlim;
        lim_q   <= cfg_in.lim;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        rdata_q <= '0;
      end
      if (step_strb && !go_wait && !wr_q) begin
        if (bsel_q) rdata_q[WORD_W-1:DATA_W] <= ad_i;
        else        rdata_q[DATA_W-1:0]      <= ad_i;
      end
      if ((state_q == XS_HOLD) && (state_d == XS_ADDR)) bsel_q <= 1'b1;
      if (state_q == XS_INTRD) begin
        rdata_q <= wide_q ? int_rdata_i : {{DATA_W{1'b0}}, int_rdata_i[DATA_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en_o    <= 1'b0;
      int_we_o    <= 1'b0;
      int_wide_o  <= 1'b0;
      int_addr_o  <= '0;
      int_wdata_o <= '0;
    end else begin
      int_en_o <= (state_d == XS_INT);
      if (accept) begin
        int_we_o    <= req_write_i;
        int_wide_o  <= req_wide_i;
        int_addr_o  <= req_addr_i;
        int_wdata_o <= req_wdata_i;
      end
    end
  end

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_d_i (state_d),
    .adv_i     (cur_adv),
    .write_i   (cur_write),
    .fetch_i   (cur_fetch),
    .baddr_i   (baddr),
    .wbyte_i   (wbyte),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ahi_o     (ahi_o),
    .strb_o    (strb_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .inst_o    (inst_o)
  );

  assign req_ready_o = idle;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_n_o,
  input logic       wr_n_o,
  input logic       strb_o,
  input logic       ad_oe_o,
  input logic       inst_o,
  input logic       int_en_o,
  input logic       rsp_valid_o,
  input logic       adv_q,
  input logic       unlim_q,
  input logic [1:0] lim_q
);

  logic [7:0] low_run;
  logic       strobe_low;

  assign strobe_low = !rd_n_o || !wr_n_o;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (strobe_low) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
    else low_run <= '0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n_o && !wr_n_o)); // R6

  AST_INT_QUIET: assert property (@(posedge clk) disable iff (rst)
    int_en_o |-> (rd_n_o && wr_n_o && !inst_o)); // R1

  AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!adv_q && strb_o && ad_oe_o && rd_n_o && wr_n_o) |=> !strb_o); // R2

  AST_WAIT_CAP: assert property (@(posedge clk) disable iff (rst)
    (!unlim_q && strobe_low) |-> (low_run < 8'd1 + 8'd2 * {6'd0, lim_q})); // R9

  AST_WAIT_PAIRS: assert property (@(posedge clk) disable iff (rst)
    (!strobe_low && low_run != 8'd0) |-> low_run[0]); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o); // R5

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .strb_o      (strb_o),
  .ad_oe_o     (ad_oe_o),
  .inst_o      (inst_o),
  .int_en_o    (int_en_o),
  .rsp_valid_o (rsp_valid_o),
  .adv_q       (adv_q),
  .unlim_q     (unlim_q),
  .lim_q       (lim_q)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_i = 4'd0;
  logic        ea_i = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_fetch_i = 1'b0, req_wide_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0, int_rdata_i = '0;
  logic        req_ready_o, rsp_valid_o, int_en_o, int_we_o, int_wide_o;
  logic [15:0] rsp_rdata_o, int_addr_o, int_wdata_o;
  logic [7:0]  ad_o, ad_i = '0, ahi_o;
  logic        ad_oe_o, strb_o, rd_n_o, wr_n_o, inst_o;
  logic        ready_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst(rst), .cfg_i(cfg_i), .ea_i(ea_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_fetch_i(req_fetch_i), .req_wide_i(req_wide_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .int_en_o(int_en_o), .int_we_o(int_we_o), .int_wide_o(int_wide_o),
    .int_addr_o(int_addr_o), .int_wdata_o(int_wdata_o), .int_rdata_i(int_rdata_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ahi_o(ahi_o), .strb_o(strb_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .inst_o(inst_o), .ready_i(ready_i)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "rd_n", rd_n_o, 1);
    chk("R11", "wr_n", wr_n_o, 1);
    chk("R11", "ad_oe", ad_oe_o, 0);
    chk("R11", "inst", inst_o, 0);
    chk("R11", "rsp_valid", rsp_valid_o, 0);
    chk("R11", "req_ready", req_ready_o, 1);
  endtask

  task automatic t_idle_level();
    @(negedge clk); cfg_i = 4'b0001;
    @(negedge clk); @(negedge clk);
    chk("R11", "idle strobe adv", strb_o, 1);
    cfg_i = 4'b0000;
    @(negedge clk); @(negedge clk);
    chk("R11", "idle strobe latch", strb_o, 0);
  endtask

  task automatic t_ext(input string tag, input bit wr, input bit fe, input bit wd,
                       input logic [15:0] addr, input logic [15:0] wdata,
                       input bit adv, input bit unlim, input int lim, input int k_low,
                       input logic [7:0] rlo, input logic [7:0] rhi, input bit ea);
    int nb;
    int w;
    int len;
    string st;
    nb = wd ? 2 : 1;
    w  = (k_low + 1) / 2;
    if (!unlim && w > lim) w = lim;
    len = 1 + 2 * w;
    st  = adv ? "R3" : "R2";
    @(negedge clk);
    ea_i = ea; cfg_i = {lim[1:0], unlim, adv};
    req_valid_i = 1'b1; req_write_i = wr; req_fetch_i = fe; req_wide_i = wd;
    req_addr_i = addr; req_wdata_i = wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int b = 0; b < nb; b++) begin
      logic [15:0] ba;
      logic [7:0]  wb;
      ba = addr + 16'(b);
      wb = b ? wdata[15:8] : wdata[7:0];
      chk("R4", "addr hi", ahi_o, ba[15:8]);
      chk("R4", "addr lo", ad_o, ba[7:0]);
      chk("R4", "ad_oe in addr", ad_oe_o, 1);
      chk(st, "strobe in addr", strb_o, adv ? 0 : 1);
      chk("R7", "inst in addr", inst_o, fe);
      chk("R1", "no int_en", int_en_o, 0);
      ready_i = 1'b1;
      @(negedge clk);
      for (int k = 1; k <= len; k++) begin
        chk(wr ? "R6" : "R5", "rd_n strobe", rd_n_o, wr);
        chk("R6", "wr_n strobe", wr_n_o, !wr);
        chk(st, "strobe in rw", strb_o, 0);
        chk("R7", "inst in rw", inst_o, fe);
        if (wr) begin
          chk("R6", "ad_oe write", ad_oe_o, 1);
          chk("R6", "write byte", ad_o, wb);
        end
        ad_i    = b ? rhi : rlo;
        ready_i = (k > k_low);
        @(negedge clk);
      end
      ready_i = 1'b1;
      chk(tag, "strobe length rd_n", rd_n_o, 1);
      chk(tag, "strobe length wr_n", wr_n_o, 1);
      chk(st, "strobe in hold", strb_o, adv);
      chk("R7", "inst in hold", inst_o, fe);
      @(negedge clk);
    end
    chk("R5", "rsp_valid", rsp_valid_o, 1);
    chk("R7", "inst idle", inst_o, 0);
    if (!wr) chk(wd ? "R10" : "R5", "read data", rsp_rdata_o, wd ? {rhi, rlo} : {8'h00, rlo});
    @(negedge clk);
    chk("R5", "rsp pulse ends", rsp_valid_o, 0);
  endtask

  task automatic t_int(input logic [15:0] addr, input bit wr, input bit wd,
                       input logic [15:0] wdata, input logic [15:0] rword);
    @(negedge clk);
    ea_i = 1'b1; cfg_i = 4'b0001;
    req_valid_i = 1'b1; req_write_i = wr; req_fetch_i = 1'b1; req_wide_i = wd;
    req_addr_i = addr; req_wdata_i = wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R1", "int_en", int_en_o, 1);
    chk("R1", "int_addr", int_addr_o, addr);
    chk("R1", "int_we", int_we_o, wr);
    chk("R1", "int rd_n quiet", rd_n_o, 1);
    chk("R1", "int wr_n quiet", wr_n_o, 1);
    chk("R7", "int inst low", inst_o, 0);
    if (wr) chk("R1", "int wdata", int_wdata_o, wdata);
    @(negedge clk);
    int_rdata_i = rword;
    chk("R1", "int_en single", int_en_o, 0);
    @(negedge clk);
    chk("R1", "int rsp", rsp_valid_o, 1);
    if (!wr) chk("R1", "int rdata", rsp_rdata_o, wd ? rword : {8'h00, rword[7:0]});
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_level();
    t_ext("R5", 0, 1, 0, 16'h0456, 16'h0000, 0, 0, 0, 0, 8'hA5, 8'h00, 0);
    t_ext("R6", 1, 0, 0, 16'h8A3C, 16'h00C3, 1, 0, 0, 0, 8'h00, 8'h00, 0);
    t_ext("R8", 0, 0, 0, 16'h1000, 16'h0000, 0, 0, 3, 3, 8'h5A, 8'h00, 0);
    t_ext("R9", 0, 0, 0, 16'h1001, 16'h0000, 1, 0, 1, 10, 8'h11, 8'h00, 0);
    t_ext("R9", 1, 0, 0, 16'h1002, 16'h0077, 0, 0, 0, 10, 8'h00, 8'h00, 0);
    t_ext("R9", 0, 1, 0, 16'h1003, 16'h0000, 1, 1, 0, 5, 8'h3E, 8'h00, 0);
    t_ext("R10", 0, 0, 1, 16'h12FF, 16'h0000, 1, 0, 2, 1, 8'h34, 8'h12, 0);
    t_ext("R10", 1, 0, 1, 16'h0A00, 16'hBEEF, 0, 0, 0, 0, 8'h00, 8'h00, 0);
    t_int(16'h2000, 0, 1, 16'h0000, 16'hCAFE);
    t_int(16'h3FFF, 0, 0, 16'h0000, 16'h12AB);
    t_int(16'h2468, 1, 1, 16'h5566, 16'h0000);
    t_ext("R1", 0, 0, 0, 16'h2000, 16'h0000, 0, 0, 0, 0, 8'h99, 8'h00, 0);
    t_ext("R1", 0, 0, 0, 16'h1FFF, 16'h0000, 0, 0, 0, 0, 8'h77, 8'h00, 1);
    t_ext("R1", 0, 0, 0, 16'h4000, 16'h0000, 1, 0, 0, 0, 8'h66, 8'h00, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule